// File: doc/BRIEF.md
# Synchronization Point Counter Bank

The block holds a bank of independent event counters that software uses to follow the progress of work in other engines. Each counter can be loaded directly, for example when a saved value is restored, and can be read at any time. A shared increment register takes a bitmask and advances every selected counter by one in a single write. Engines advance counters through a per-counter strobe input. A second array of wait-base registers is kept next to the counters. These registers are plain storage that software can read and write.

A threshold query port takes a counter number and a threshold. It reports at once whether that counter has already reached the threshold. The test uses signed difference arithmetic, so it stays correct when a counter wraps around 32 bits. Counter 0 is reserved. It always reads zero, so a query against it with threshold 0 is always satisfied and can serve as a wait that never blocks.

Registers sit on a byte-addressed word bus. Bits [9:8] of the address select the region: 0 for counters, 1 for wait bases, 2 for the increment register. Bits [7:2] give the index within the region.

Top module: `sync_counter_bank`

## Requirements
- R1: A write to byte address 0x000 + 4n with n from 0 to 31 loads counter n. A read of that address returns the counter's value as it stands in the request cycle. Read data appears on rdata_o with rvalid_o high in the cycle after the request, and rvalid_o is low in cycles that follow no read.
- R2: The 8 wait-base registers sit at 0x100 + 4n. Each holds a full 32-bit word that can be written and read back. Writing them changes no counter, and no wait base changes without a bus write.
- R3: A write to the increment register at 0x200 adds one to every counter n whose bit n is set in the written word. Counters whose bit is clear keep their value.
- R4: Each bit n of hw_incr_i that is high at a clock edge adds one to counter n. If a bus increment selects the same counter in that cycle, the counter rises by two.
- R5: When a direct bus write to a counter and an increment of that counter (from the bus or from hw_incr_i) fall in the same cycle, the written value is stored and the increment is lost.
- R6: Counter 0 always reads zero. Writes to it and increments of it are ignored.
- R7: thr_met_o is high in the same cycle exactly when the 32-bit difference (counter[thr_id_i] − thr_val_i), taken as a signed number, is zero or positive. This stays correct across wraparound.
- R8: A read of the increment register returns zero and changes no counter.
- R9: An active-low asynchronous reset clears every counter, every wait base, rdata_o and rvalid_o to zero.
- R10: Unmapped accesses read zero and their writes are ignored. These are counter-region indices of 32 or more, wait-base indices of 8 or more, region 3, and any address with bits [1:0] not zero.
- R11: A counter at 0xFFFFFFFF that is incremented once wraps to 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| hw_incr_i | input | 32 | Engine-side increment strobes, one bit per counter |
| thr_id_i | input | 5 | Counter selected for the threshold query |
| thr_val_i | input | 32 | Threshold for the query |
| thr_met_o | output | 1 | Selected counter has reached the threshold |

## Verification
Some properties are checked on every cycle:
- read latency and the rvalid_o pattern;
- a query against counter 0 at threshold 0 is always met;
- a query whose threshold equals the selected counter's value is always met;
- reads of the increment register return zero;
- without a bus write, no counter moves by more than two per cycle;
- without a bus write, no wait base changes.

Other behaviour only the bench scenarios show:
- which exact counters a bitmask moves;
- that a direct write wins over a simultaneous increment;
- the wrap of a counter from all ones to zero;
- the expiry result for thresholds on either side of the half-range boundary;
- that unmapped or misaligned writes leave the stored state unchanged.

// File: rtl/sync_bank_pkg.sv
package sync_bank_pkg;
  typedef enum logic [1:0] {
    RG_CNT  = 2'd0,
    RG_WB   = 2'd1,
    RG_INCR = 2'd2,
    RG_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/sync_bus_decode.sv
module sync_bus_decode
  import sync_bank_pkg::*;
#(
  parameter int NUM_CNT  = 32,
  parameter int NUM_BASE = 8,
  parameter int REG_LSB  = 8,
  localparam int ADDR_W   = REG_LSB + 2,
  localparam int IDX_W    = REG_LSB - 2,
  localparam int ID_W     = $clog2(NUM_CNT),
  localparam int WB_ID_W  = $clog2(NUM_BASE)
) (
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_CNT-1:0]  cnt_wr_o,
  output logic [NUM_BASE-1:0] wb_wr_o,
  output logic                incr_wr_o,
  output region_e             sel_o,
  output logic [ID_W-1:0]     cnt_idx_o,
  output logic [WB_ID_W-1:0]  wb_idx_o
);
  localparam logic [IDX_W:0] CNT_LIM = (IDX_W+1)'(NUM_CNT);
  localparam logic [IDX_W:0] WB_LIM  = (IDX_W+1)'(NUM_BASE);

  logic [1:0]       region;
  logic [IDX_W-1:0] idx;
  logic             aligned, hit_cnt, hit_wb, hit_incr, wr;

  assign region  = addr_i[ADDR_W-1:REG_LSB];
  assign idx     = addr_i[REG_LSB-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = req_i & we_i;

  assign hit_cnt  = aligned && (region == RG_CNT)  && ({1'b0, idx} < CNT_LIM);
  assign hit_wb   = aligned && (region == RG_WB)   && ({1'b0, idx} < WB_LIM);
  assign hit_incr = aligned && (region == RG_INCR) && (idx == '0);

  always_comb begin
    if (hit_cnt)       sel_o = RG_CNT;
    else if (hit_wb)   sel_o = RG_WB;
    else if (hit_incr) sel_o = RG_INCR;
    else               sel_o = RG_NONE;
  end

  assign cnt_idx_o = idx[ID_W-1:0];
  assign wb_idx_o  = idx[WB_ID_W-1:0];
  assign incr_wr_o = wr & hit_incr;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt_we
    assign cnt_wr_o[i] = wr & hit_cnt & (idx == IDX_W'(i));
  end
  for (genvar i = 0; i < NUM_BASE; i++) begin : g_wb_we
    assign wb_wr_o[i] = wr & hit_wb & (idx == IDX_W'(i));
  end
endmodule

// File: rtl/sync_cnt_cell.sv
module sync_cnt_cell #(
  parameter int CNT_W    = 32,
  parameter bit RESERVED = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             cpu_inc_i,
  input  logic             hw_inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, step;

  assign step  = CNT_W'(cpu_inc_i) + CNT_W'(hw_inc_i);
  // direct write overrides any same-cycle increment
  assign cnt_d = wr_i ? wdata_i : cnt_q + step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!RESERVED) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sync_expiry_cmp.sv
module sync_expiry_cmp #(
  parameter int NUM_CNT = 32,
  parameter int CNT_W   = 32,
  localparam int ID_W   = $clog2(NUM_CNT)
) (
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_i,
  input  logic [ID_W-1:0]               id_i,
  input  logic [CNT_W-1:0]              thr_i,
  output logic                          met_o
);
  logic [CNT_W-1:0] diff;
  // signed distance keeps the test valid across wraparound
  assign diff  = cnt_i[id_i] - thr_i;
  assign met_o = ~diff[CNT_W-1];
endmodule

// File: rtl/sync_counter_bank.sv
module sync_counter_bank
  import sync_bank_pkg::*;
#(
  parameter int NUM_CNT  = 32,
  parameter int CNT_W    = 32,
  parameter int NUM_BASE = 8,
  parameter int REG_LSB  = 8,
  localparam int ADDR_W   = REG_LSB + 2,
  localparam int ID_W     = $clog2(NUM_CNT),
  localparam int WB_ID_W  = $clog2(NUM_BASE)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]   rdata_o,
  output logic               rvalid_o,
  input  logic [NUM_CNT-1:0] hw_incr_i,
  input  logic [ID_W-1:0]    thr_id_i,
  input  logic [CNT_W-1:0]   thr_val_i,
  output logic               thr_met_o
);
  logic [NUM_CNT-1:0]             cnt_wr, cpu_inc;
  logic [NUM_BASE-1:0]            wb_wr;
  logic                           incr_wr;
  region_e                        sel;
  logic [ID_W-1:0]                cnt_idx;
  logic [WB_ID_W-1:0]             wb_idx;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_q;
  logic [NUM_BASE-1:0][CNT_W-1:0] wb_q;
  logic [CNT_W-1:0]               rd_mux;

  sync_bus_decode #(
    .NUM_CNT (NUM_CNT),
    .NUM_BASE(NUM_BASE),
    .REG_LSB (REG_LSB)
  ) u_dec (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .cnt_wr_o (cnt_wr),
    .wb_wr_o  (wb_wr),
    .incr_wr_o(incr_wr),
    .sel_o    (sel),
    .cnt_idx_o(cnt_idx),
    .wb_idx_o (wb_idx)
  );

  assign cpu_inc = incr_wr ? wdata_i[NUM_CNT-1:0] : '0;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    sync_cnt_cell #(
      .CNT_W   (CNT_W),
      .RESERVED(i == 0)
    ) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (cnt_wr[i]),
      .wdata_i  (wdata_i),
      .cpu_inc_i(cpu_inc[i]),
      .hw_inc_i (hw_incr_i[i]),
      .cnt_o    (cnt_q[i])
    );
  end

  for (genvar i = 0; i < NUM_BASE; i++) begin : g_wb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       wb_q[i] <= '0;
      else if (wb_wr[i]) wb_q[i] <= wdata_i;
    end
  end

  sync_expiry_cmp #(
    .NUM_CNT(NUM_CNT),
    .CNT_W  (CNT_W)
  ) u_cmp (
    .cnt_i(cnt_q),
    .id_i (thr_id_i),
    .thr_i(thr_val_i),
    .met_o(thr_met_o)
  );

  always_comb begin
    unique case (sel)
      RG_CNT:  rd_mux = cnt_q[cnt_idx];
      RG_WB:   rd_mux = wb_q[wb_idx];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= req_i & ~we_i;
      rdata_o  <= (req_i & ~we_i) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/sync_counter_bank_chk.sv
module sync_counter_bank_chk #(
  parameter int NUM_CNT  = 32,
  parameter int CNT_W    = 32,
  parameter int NUM_BASE = 8,
  parameter int REG_LSB  = 8,
  localparam int ADDR_W  = REG_LSB + 2,
  localparam int ID_W    = $clog2(NUM_CNT)
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           req_i,
  input logic                           we_i,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [CNT_W-1:0]               rdata_o,
  input logic                           rvalid_o,
  input logic [ID_W-1:0]                thr_id_i,
  input logic [CNT_W-1:0]               thr_val_i,
  input logic                           thr_met_o,
  input logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_q,
  input logic [NUM_BASE-1:0][CNT_W-1:0] wb_q
);
  localparam logic [ADDR_W-1:0] INCR_ADDR = ADDR_W'(2) << REG_LSB;

  p_rvalid_read_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  p_rvalid_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  p_zero_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_id_i == '0 && thr_val_i == '0) |-> thr_met_o);

  p_self_met_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_val_i == cnt_q[thr_id_i]) |-> thr_met_o);

  p_incr_read_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == INCR_ADDR) |=> (rdata_o == '0));

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_step
    p_step_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(req_i && we_i) |=> ((cnt_q[g] - $past(cnt_q[g])) <= CNT_W'(2)));
  end

  for (genvar g = 0; g < NUM_BASE; g++) begin : g_wb
    p_wb_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(req_i && we_i) |=> $stable(wb_q[g]));
  end
endmodule

bind sync_counter_bank sync_counter_bank_chk #(
  .NUM_CNT (NUM_CNT),
  .CNT_W   (CNT_W),
  .NUM_BASE(NUM_BASE),
  .REG_LSB (REG_LSB)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o),
  .thr_id_i (thr_id_i),
  .thr_val_i(thr_val_i),
  .thr_met_o(thr_met_o),
  .cnt_q    (cnt_q),
  .wb_q     (wb_q)
);

// File: tb/sync_counter_bank_tb_top.sv
`timescale 1ns/1ps
module sync_counter_bank_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [9:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o;
  logic [31:0] hw_incr_i = '0;
  logic [4:0]  thr_id_i = '0;
  logic [31:0] thr_val_i = '0;
  logic        thr_met_o;

  int n_run = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  sync_counter_bank dut_i (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .rvalid_o, .hw_incr_i, .thr_id_i, .thr_val_i, .thr_met_o
  );

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 10'h004, 32'h0000_0011, 8'd1},  // R1 load
    '{1'b0, 10'h004, 32'h0000_0011, 8'd1},  // R1 read back
    '{1'b1, 10'h07C, 32'hDEAD_BEEF, 8'd1},  // R1 top counter
    '{1'b0, 10'h07C, 32'hDEAD_BEEF, 8'd1},
    '{1'b1, 10'h104, 32'h0000_0055, 8'd2},  // R2 wait base 1
    '{1'b0, 10'h104, 32'h0000_0055, 8'd2},
    '{1'b0, 10'h004, 32'h0000_0011, 8'd2},  // R2 counter 1 untouched
    '{1'b1, 10'h200, 32'h8000_0012, 8'd3},  // R3 bits 1,4,31
    '{1'b0, 10'h004, 32'h0000_0012, 8'd3},
    '{1'b0, 10'h010, 32'h0000_0001, 8'd3},
    '{1'b0, 10'h07C, 32'hDEAD_BEF0, 8'd3},
    '{1'b0, 10'h008, 32'h0000_0000, 8'd3},  // R3 bit 2 clear
    '{1'b0, 10'h200, 32'h0000_0000, 8'd8},  // R8 reads zero
    '{1'b0, 10'h004, 32'h0000_0012, 8'd8},  // R8 no side effect
    '{1'b1, 10'h000, 32'h0000_0099, 8'd6},  // R6 write ignored
    '{1'b1, 10'h200, 32'h0000_0001, 8'd6},  // R6 increment ignored
    '{1'b0, 10'h000, 32'h0000_0000, 8'd6},
    '{1'b1, 10'h0C0, 32'h0000_0077, 8'd10}, // R10 counter index 48
    '{1'b0, 10'h0C0, 32'h0000_0000, 8'd10},
    '{1'b1, 10'h120, 32'h0000_0033, 8'd10}, // R10 wait base index 8
    '{1'b0, 10'h120, 32'h0000_0000, 8'd10},
    '{1'b1, 10'h006, 32'h0000_0044, 8'd10}, // R10 misaligned
    '{1'b0, 10'h004, 32'h0000_0012, 8'd10},
    '{1'b0, 10'h11C, 32'h0000_0000, 8'd2},  // R2 last wait base
    '{1'b1, 10'h00C, 32'hFFFF_FFFF, 8'd11}, // R11 wrap
    '{1'b1, 10'h200, 32'h0000_0008, 8'd11},
    '{1'b0, 10'h00C, 32'h0000_0000, 8'd11}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    d = rvalid_o ? rdata_o : 32'hBAD0_BAD0;
  endtask

  task automatic thr_q(input string tag, input logic [4:0] id, input logic [31:0] t,
                       input logic exp);
    @(negedge clk_i);
    thr_id_i = id; thr_val_i = t;
    #1 chk(tag, {31'd0, thr_met_o}, {31'd0, exp});
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    #2;
    chk("R9 rvalid in reset", {31'd0, rvalid_o}, 32'd0);
    chk("R9 rdata in reset", rdata_o, 32'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_wr(VECS[i].addr, VECS[i].data);
      else begin
        bus_rd(VECS[i].addr, r);
        chk($sformatf("R%0d vec %0d", VECS[i].req, i), r, VECS[i].data);
      end
    end

    // R4 engine strobes, three cycles on counter 20, counter 0 strobed too
    bus_wr(10'h050, 32'd0);
    @(negedge clk_i);
    hw_incr_i = 32'h0010_0001;
    repeat (3) @(negedge clk_i);
    hw_incr_i = '0;
    bus_rd(10'h050, r); chk("R4 hw strobes", r, 32'd3);
    bus_rd(10'h000, r); chk("R6 hw strobe counter0", r, 32'd0);

    // R4 bus and engine increment together -> +2
    bus_wr(10'h018, 32'd7);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 10'h200; wdata_i = 32'h40;
    hw_incr_i = 32'h40;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; hw_incr_i = '0;
    bus_rd(10'h018, r); chk("R4 dual increment", r, 32'd9);

    // R5 direct write beats engine increment
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 10'h014; wdata_i = 32'h100;
    hw_incr_i = 32'h20;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; hw_incr_i = '0;
    bus_rd(10'h014, r); chk("R5 write wins", r, 32'h100);

    // R7 threshold queries
    bus_wr(10'h014, 32'h10);
    thr_q("R7 equal", 5'd5, 32'h10, 1'b1);
    thr_q("R7 above", 5'd5, 32'h11, 1'b0);
    thr_q("R7 below", 5'd5, 32'h0F, 1'b1);
    bus_wr(10'h024, 32'd5);
    thr_q("R7 wrap passed", 5'd9, 32'hFFFF_FFF0, 1'b1);
    thr_q("R7 half range met", 5'd9, 32'h8000_0006, 1'b1);
    thr_q("R7 half range not met", 5'd9, 32'h8000_0005, 1'b0);
    thr_q("R6 zero wait", 5'd0, 32'd0, 1'b1);

    // R9 reset clears state
    bus_wr(10'h104, 32'h1234);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R9 rvalid reset", {31'd0, rvalid_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    bus_rd(10'h010, r); chk("R9 counter cleared", r, 32'd0);
    bus_rd(10'h104, r); chk("R9 wait base cleared", r, 32'd0);

    finish_run();
  end
endmodule